// File: doc/BRIEF.md
# ADC Command Queue Scan Controller

This block sits between a command FIFO and an analog converter's command input. It steps through a queue of command words and hands each one on with a valid/ready handshake. It only does this while the queue is triggered. Each word carries control bits in its low byte:

- end-of-queue flag
- pause flag
- internal/external buffer select
- buffer number
- read/write indication

The controller decodes these bits to decide where the queue goes next. The remaining bits pass through untouched.

Software arms an idle queue. A rising edge on the trigger input then starts the transfer. A pause bit ends a sub-queue and sends the queue back to waiting for the next trigger edge. An end-of-queue bit finishes the scan. In single-scan mode the queue then drops to idle and needs re-arming. In continuous-scan mode it goes straight back to waiting for a trigger. A transfer counter reports the position in the queue, and two sticky flags record that an end-of-queue or pause command went through.

Top module: `cmdq_scan_ctrl`

## Requirements
- R1: After reset the status is idle (code 0), the transfer counter is 0, both sticky flags are 0, and neither `cmdReady` nor `outValid` is high.
- R2: A high `armIn` while idle moves the status to waiting (code 1) on the next edge. Trigger edges seen while idle are ignored, and `armIn` has no effect in any other status.
- R3: While waiting, a rising edge of `trigIn` (high now, low at the previous clock) moves the status to triggered (code 2). A trigger that stays high, or an edge seen while already triggered, does nothing.
- R4: While triggered, `outValid` equals `cmdValid`, `cmdReady` equals `cvReady`, and `outCmd` equals `cmdData`. A transfer is a cycle where both are high. In any other status, `outValid` and `cmdReady` are 0.
- R5: `outExtBuf` is bit 5 of `cmdData` (1 = external buffer), `outBufSel` is bit 6 (buffer 0 or 1), and `outRead` is bit 7 (1 = read, 0 = write).
- R6: A transfer whose bit 0 (end-of-queue) is clear adds one to the transfer counter, wrapping modulo 2^CNT_W.
- R7: A transfer with bit 0 set returns the transfer counter to 0.
- R8: A transfer with bit 1 (pause) set and bit 0 clear returns the status to waiting.
- R9: A transfer with bit 0 set goes to idle when `modeCont` is 0 (single scan) and to waiting when `modeCont` is 1 (continuous scan).
- R10: When bits 0 and 1 are both set in one transferred command, both sticky flags are set, and the status follows R9 alone.
- R11: `eoqFlag` and `pauseFlag` are set by the matching transfers and stay set until their clear strobe (`eoqClr`, `pauseClr`) is high. A clear in the same cycle as a set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armIn | input | 1 | Arms an idle queue |
| trigIn | input | 1 | Trigger, edge sensitive |
| modeCont | input | 1 | 0 single scan, 1 continuous scan |
| cmdData | input | CMD_W | Command word from the FIFO |
| cmdValid | input | 1 | FIFO word valid |
| cmdReady | output | 1 | Word taken from the FIFO |
| outCmd | output | CMD_W | Command forwarded to the converter |
| outValid | output | 1 | Forwarded command valid |
| cvReady | input | 1 | Converter accepts a command |
| outExtBuf | output | 1 | External buffer select |
| outBufSel | output | 1 | Target buffer number |
| outRead | output | 1 | Read command indication |
| qState | output | 2 | Queue status code |
| xferCnt | output | CNT_W | Transfer counter |
| eoqFlag | output | 1 | Sticky end-of-queue flag |
| pauseFlag | output | 1 | Sticky pause flag |
| eoqClr | input | 1 | Clear strobe for eoqFlag |
| pauseClr | input | 1 | Clear strobe for pauseFlag |

## Verification
The hardest case to reach from the ports is a wrap of the transfer counter. It needs more than 2^CNT_W transfers in a row with no end-of-queue bit, all inside one triggered run. A directed phase arms and triggers once, then streams that many clear-bit commands. Clear strobes that coincide with flag sets are also rare. A randomized phase makes them common by biasing the clear strobes and the end-of-queue and pause bits, and it toggles the mode and trigger so that every status transition is taken many times.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRIG = 2'd2
  } qState_e;

  // Bit positions inside the command word (decoded downstream)
  localparam int BIT_EOQ   = 0;
  localparam int BIT_PAUSE = 1;
  localparam int BIT_EXT   = 5;
  localparam int BIT_BUF   = 6;
  localparam int BIT_RD    = 7;

  typedef struct packed {
    logic xfer;
    logic clrCnt;
    logic incCnt;
    logic setEoq;
    logic setPause;
  } ctlStrobe_t;
endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [CMD_W-1:0] cmdIn,
  input  ctlStrobe_t       strobe,
  input  logic             eoqClr,
  input  logic             pauseClr,
  output logic             trigRise,
  output logic             cmdEoq,
  output logic             cmdPause,
  output logic [CMD_W-1:0] cmdOut,
  output logic             extBuf,
  output logic             bufSel,
  output logic             rdCmd,
  output logic [CNT_W-1:0] xferCnt,
  output logic             eoqFlag,
  output logic             pauseFlag
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic trigPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigIn;
  end
  assign trigRise = trigIn & ~trigPrev;

  assign cmdOut   = cmdIn;
  assign cmdEoq   = cmdIn[BIT_EOQ];
  assign cmdPause = cmdIn[BIT_PAUSE];
  assign extBuf   = cmdIn[BIT_EXT];
  assign bufSel   = cmdIn[BIT_BUF];
  assign rdCmd    = cmdIn[BIT_RD];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              xferCnt <= '0;
    else if (strobe.clrCnt) xferCnt <= '0;
    else if (strobe.incCnt) xferCnt <= xferCnt + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eoqFlag   <= 1'b0;
      pauseFlag <= 1'b0;
    end else begin
      if (eoqClr)               eoqFlag <= 1'b0;
      else if (strobe.setEoq)   eoqFlag <= 1'b1;
      if (pauseClr)             pauseFlag <= 1'b0;
      else if (strobe.setPause) pauseFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/cmdq_control.sv
module cmdq_control
  import cmdq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armIn,
  input  logic       trigRise,
  input  logic       modeCont,
  input  logic       cmdValid,
  input  logic       cvReady,
  input  logic       cmdEoq,
  input  logic       cmdPause,
  output qState_e    state,
  output logic       cmdReady,
  output logic       outValid,
  output ctlStrobe_t strobe
);
  qState_e stateNxt;
  logic    active;

  assign active   = (state == ST_TRIG);
  assign outValid = active & cmdValid;
  assign cmdReady = active & cvReady;

  always_comb begin
    strobe          = '0;
    strobe.xfer     = active & cmdValid & cvReady;
    strobe.clrCnt   = strobe.xfer & cmdEoq;
    strobe.incCnt   = strobe.xfer & ~cmdEoq;
    strobe.setEoq   = strobe.xfer & cmdEoq;
    strobe.setPause = strobe.xfer & cmdPause;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (armIn) stateNxt = ST_WAIT;
      ST_WAIT: if (trigRise) stateNxt = ST_TRIG;
      ST_TRIG: begin
        if (strobe.xfer) begin
          if (cmdEoq)        stateNxt = modeCont ? ST_WAIT : ST_IDLE;
          else if (cmdPause) stateNxt = ST_WAIT;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/cmdq_scan_ctrl.sv
module cmdq_scan_ctrl
  import cmdq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armIn,
  input  logic             trigIn,
  input  logic             modeCont,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             cmdValid,
  output logic             cmdReady,
  output logic [CMD_W-1:0] outCmd,
  output logic             outValid,
  input  logic             cvReady,
  output logic             outExtBuf,
  output logic             outBufSel,
  output logic             outRead,
  output logic [1:0]       qState,
  output logic [CNT_W-1:0] xferCnt,
  output logic             eoqFlag,
  output logic             pauseFlag,
  input  logic             eoqClr,
  input  logic             pauseClr
);
  ctlStrobe_t strobe;
  qState_e    state;
  logic       trigRise, cmdEoq, cmdPause;

  cmdq_control u_ctl (
    .clk(clk), .rstN(rstN), .armIn(armIn), .trigRise(trigRise),
    .modeCont(modeCont), .cmdValid(cmdValid), .cvReady(cvReady),
    .cmdEoq(cmdEoq), .cmdPause(cmdPause), .state(state),
    .cmdReady(cmdReady), .outValid(outValid), .strobe(strobe)
  );

  cmdq_datapath #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cmdIn(cmdData),
    .strobe(strobe), .eoqClr(eoqClr), .pauseClr(pauseClr),
    .trigRise(trigRise), .cmdEoq(cmdEoq), .cmdPause(cmdPause),
    .cmdOut(outCmd), .extBuf(outExtBuf), .bufSel(outBufSel),
    .rdCmd(outRead), .xferCnt(xferCnt), .eoqFlag(eoqFlag),
    .pauseFlag(pauseFlag)
  );

  assign qState = state;
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             armIn,
  input logic             modeCont,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic             outValid,
  input logic             bitEoq,
  input logic             bitPause,
  input logic [1:0]       qState,
  input logic [CNT_W-1:0] xferCnt,
  input logic             eoqFlag,
  input logic             pauseFlag,
  input logic             eoqClr,
  input logic             pauseClr
);
  logic xfer;
  assign xfer = cmdValid & cmdReady;

  AST_IDLE_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    (qState != 2'd2) |-> (!outValid && !cmdReady)); // R4
  AST_ARM_TO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (qState == 2'd0 && armIn) |=> (qState == 2'd1)); // R2
  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !bitEoq) |=> (xferCnt == CNT_W'($past(xferCnt) + 1'b1))); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && bitEoq) |=> (xferCnt == '0)); // R7
  AST_PAUSE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && bitPause && !bitEoq) |=> (qState == 2'd1)); // R8
  AST_EOQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && bitEoq && !modeCont) |=> (qState == 2'd0)); // R9
  AST_EOQ_CONT: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && bitEoq && modeCont) |=> (qState == 2'd1)); // R9
  AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && bitEoq && bitPause && !eoqClr && !pauseClr) |=> (eoqFlag && pauseFlag)); // R10
  AST_EOQ_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    eoqClr |=> !eoqFlag); // R11
  AST_PAUSE_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    pauseClr |=> !pauseFlag); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (eoqFlag && !eoqClr) |=> eoqFlag); // R11
endmodule

bind cmdq_scan_ctrl cmdq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .armIn(armIn), .modeCont(modeCont),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .outValid(outValid),
  .bitEoq(cmdData[0]), .bitPause(cmdData[1]), .qState(qState),
  .xferCnt(xferCnt), .eoqFlag(eoqFlag), .pauseFlag(pauseFlag),
  .eoqClr(eoqClr), .pauseClr(pauseClr)
);

// File: tb/tb_cmdq_scan_ctrl.sv
module tb_cmdq_scan_ctrl;
  localparam int CMD_W = 32;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armIn = 0, trigIn = 0, modeCont = 0, cmdValid = 0, cvReady = 0;
  logic eoqClr = 0, pauseClr = 0;
  logic [CMD_W-1:0] cmdData = '0;
  logic cmdReady, outValid, outExtBuf, outBufSel, outRead, eoqFlag, pauseFlag;
  logic [CMD_W-1:0] outCmd;
  logic [1:0] qState;
  logic [CNT_W-1:0] xferCnt;

  int nChecks = 0, nFail = 0;
  // reference model state
  int mSt = 0, mCnt = 0;
  bit mEoq = 0, mPause = 0, mTrigPrev = 0;

  always #5 clk = ~clk;

  cmdq_scan_ctrl #(.CMD_W(CMD_W), .CNT_W(CNT_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit trig = (mSt == 2);
    chk(qState == 2'(mSt), "R2/R3/R8/R9 state", qState, mSt);
    chk(xferCnt == CNT_W'(mCnt), "R6/R7 counter", xferCnt, mCnt);
    chk(eoqFlag == mEoq, "R11 eoq flag", eoqFlag, mEoq);
    chk(pauseFlag == mPause, "R10/R11 pause flag", pauseFlag, mPause);
    chk(outValid == (trig && cmdValid), "R4 outValid", outValid, trig && cmdValid);
    chk(cmdReady == (trig && cvReady), "R4 cmdReady", cmdReady, trig && cvReady);
    chk(outCmd == cmdData, "R4 outCmd", outCmd, cmdData);
    chk({outRead, outBufSel, outExtBuf} == cmdData[7:5], "R5 fields",
        {outRead, outBufSel, outExtBuf}, cmdData[7:5]);
  endtask

  task automatic modelStep();
    bit rise = trigIn && !mTrigPrev;
    bit xfer = (mSt == 2) && cmdValid && cvReady;
    int nSt = mSt;
    if (mSt == 0 && armIn) nSt = 1;
    else if (mSt == 1 && rise) nSt = 2;
    else if (xfer) begin
      if (cmdData[0]) nSt = modeCont ? 1 : 0;
      else if (cmdData[1]) nSt = 1;
    end
    if (xfer) mCnt = cmdData[0] ? 0 : (mCnt + 1) % (1 << CNT_W);
    if (eoqClr) mEoq = 0; else if (xfer && cmdData[0]) mEoq = 1;
    if (pauseClr) mPause = 0; else if (xfer && cmdData[1]) mPause = 1;
    mTrigPrev = trigIn;
    mSt = nSt;
  endtask

  task automatic step(input bit arm, input bit trg, input bit mode, input bit vld,
                      input logic [CMD_W-1:0] dat, input bit rdy, input bit eC, input bit pC);
    armIn = arm; trigIn = trg; modeCont = mode; cmdValid = vld;
    cmdData = dat; cvReady = rdy; eoqClr = eC; pauseClr = pC;
    #1;
    compareAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    chk(qState == 2'd0 && xferCnt == 0 && !eoqFlag && !pauseFlag, "R1 reset", qState, 0);
    chk(!cmdReady && !outValid, "R1 no handshake", cmdReady, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: trigger edge while idle ignored
    step(0, 1, 0, 1, 32'h0, 1, 0, 0);
    step(0, 0, 0, 1, 32'h0, 1, 0, 0);
    step(1, 0, 0, 0, 32'h0, 0, 0, 0);          // arm -> wait
    step(1, 0, 0, 0, 32'h0, 0, 0, 0);          // arm in wait ignored (R2)
    // R3: edge -> triggered, held level no retrigger
    step(0, 1, 0, 0, 32'h0, 0, 0, 0);
    step(0, 1, 0, 1, 32'hA0, 0, 0, 0);         // stalled by cvReady (R4)
    step(0, 1, 0, 1, 32'h20, 1, 0, 0);         // R5 ext, R6 count
    step(0, 0, 0, 1, 32'hC0, 1, 0, 0);
    step(0, 0, 0, 1, 32'h42, 1, 0, 0);         // R8 pause -> wait
    step(0, 0, 0, 1, 32'h0, 1, 0, 0);          // no forwarding while waiting
    step(0, 1, 0, 0, 32'h0, 0, 0, 0);          // R3 retrigger
    step(0, 1, 0, 1, 32'h81, 1, 0, 1);         // R9 eoq single -> idle, R11 pause clear
    step(0, 0, 0, 0, 32'h0, 0, 0, 0);
    // R9 continuous, R10 both bits, R11 clear wins
    step(1, 0, 1, 0, 32'h0, 0, 0, 0);
    step(0, 1, 1, 0, 32'h0, 0, 0, 0);
    step(0, 1, 1, 1, 32'h3, 1, 0, 0);          // R10 both -> wait (cont)
    step(0, 0, 1, 0, 32'h0, 0, 0, 0);
    step(0, 1, 1, 0, 32'h0, 0, 0, 0);
    step(0, 1, 1, 1, 32'h3, 1, 1, 1);          // R11 clear wins same cycle
    step(0, 0, 0, 0, 32'h0, 0, 0, 0);
    // R6 counter wrap in one triggered run
    step(0, 1, 0, 0, 32'h0, 0, 0, 0);
    for (int i = 0; i < (1 << CNT_W) + 3; i++)
      step(0, 0, 0, 1, CMD_W'(i) << 8, 1, 0, 0);
    step(0, 0, 0, 0, 32'h0, 0, 0, 0);
    // randomized phase
    for (int i = 0; i < 3000; i++) begin
      logic [CMD_W-1:0] d = $urandom;
      d[0] = ($urandom % 8 == 0);
      d[1] = ($urandom % 6 == 0);
      step(($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
           ($urandom % 4) != 0, d, ($urandom % 3) != 0,
           ($urandom % 7) == 0, ($urandom % 7) == 0);
    end
    summary();
    $finish;
  end
endmodule